// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt Controller

This block watches the running calendar time (minute, hour, weekday and date, each a 7-bit BCD value). It compares that time against four programmable alarm fields. Each alarm field has its own exclude bit, so a field can be left out of the comparison. The comparison is made only on a once-per-minute update strobe. When every included field matches, the block sets a sticky alarm flag.

The interrupt output is an active-low, open-drain request. It is modelled as an output-enable that pulls the line low whenever the flag and the interrupt enable are both set. Software can raise or release the line at any time by changing the enable, even while the flag stays set. Software can also release the line by clearing the flag.

A simple synchronous register port gives access to the four alarm registers and to one control register. Write data takes effect on the clock edge that samples the write. Read data comes from a register and appears one cycle after the address is presented.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After synchronous reset every alarm register reads 0x00, the control register reads 0x00 and `int_pull_low` is 0.
- R2: The alarm registers sit at addresses 0x9 (minute), 0xA (hour), 0xB (weekday) and 0xC (date). Each stores all 8 written bits, and its value appears on `reg_rdata` in the cycle after the address is presented.
- R3: The control register is at address 0x1, with bit 0 = interrupt enable and bit 1 = alarm flag. Bits 7..2 always read 0. Unmapped addresses read 0x00.
- R4: A cycle with `minute_tick` = 1 produces an alarm event when every included field's bits 6..0 equal the matching current-time input. The event sets the flag on that clock edge.
- R5: An alarm register with bit 7 = 1 is excluded: its field takes no part in the comparison.
- R6: When all four exclude bits are 1, no alarm event ever occurs.
- R7: Without `minute_tick` no event occurs, even if the time matches.
- R8: The flag stays 1 until a control write with bit 1 = 0. A control write with bit 1 = 1 leaves the flag unchanged. An event in the same cycle as a clearing write wins, and the flag ends at 1.
- R9: `int_pull_low` equals flag AND enable. It changes in the same cycle in which a control write or an event updates them.
- R10: An event while the enable is 0 sets the flag but leaves the line released. Setting the enable afterwards pulls the line low at once.
- R11: Clearing the enable while the line is low releases it and leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_minute | input | 7 | Current minute, BCD |
| cur_hour | input | 7 | Current hour, BCD |
| cur_weekday | input | 7 | Current weekday code |
| cur_date | input | 7 | Current day of month, BCD |
| minute_tick | input | 1 | One-cycle strobe at each minute update |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| int_pull_low | output | 1 | Pulls the open-drain interrupt line low when 1 |

## Verification
Each result has a fixed due time:
- A register write, or a `minute_tick` with its time inputs, is driven at a falling edge. The flag and enable update on the next rising edge, so `int_pull_low` is due at the falling edge that follows.
- A read address driven at a falling edge gives its data on `reg_rdata` one rising edge later, and the data is sampled at the next falling edge.

The bench tasks hold each stimulus for exactly one clock and sample only at those falling edges. Every result is compared against a bench model that is updated at the same point.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int REG_W      = 8;
  localparam int TIME_W     = REG_W - 1;
  localparam int ADDR_W     = 4;
  localparam logic [ADDR_W-1:0] ALARM_BASE = 4'h9;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 4'h1;
  localparam int EN_BIT   = 0;
  localparam int FLAG_BIT = 1;
  localparam int EXCL_BIT = REG_W - 1;

  typedef enum logic [1:0] {
    FLD_MINUTE  = 2'd0,
    FLD_HOUR    = 2'd1,
    FLD_WEEKDAY = 2'd2,
    FLD_DATE    = 2'd3
  } alarm_field_e;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import rtc_alarm_pkg::*;
#(
  parameter int N  = NUM_FIELDS,
  parameter int DW = REG_W,
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] BASE = ALARM_BASE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  output logic [N-1:0][DW-1:0]  alarm_q
);
  // one storage register per field, each with its own address decode
  for (genvar g = 0; g < N; g++) begin : g_field
    localparam logic [AW-1:0] MY_ADDR = BASE + AW'(g);
    logic sel;
    assign sel = wr_en && (wr_addr == MY_ADDR);
    always_ff @(posedge clk) begin
      if (rst)      alarm_q[g] <= '0;
      else if (sel) alarm_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import rtc_alarm_pkg::*;
#(
  parameter int N  = NUM_FIELDS,
  parameter int DW = REG_W,
  localparam int TW = DW - 1
) (
  input  logic [N-1:0][DW-1:0] alarm_q,
  input  logic [N-1:0][TW-1:0] cur_time,
  input  logic                 tick,
  output logic                 excl_all,
  output logic                 evt
);
  logic [N-1:0] hit;
  logic [N-1:0] excl;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign excl[g] = alarm_q[g][DW-1];
    assign hit[g]  = excl[g] || (alarm_q[g][TW-1:0] == cur_time[g]);
  end

  assign excl_all = &excl;
  assign evt      = tick && (&hit) && !excl_all;
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic ctrl_wr,
  input  logic wr_en_bit,
  input  logic wr_flag_bit,
  output logic flag_q,
  output logic en_q,
  output logic pull_low
);
  // flag: an event sets it; only writing 0 clears it; an event beats a clear
  always_ff @(posedge clk) begin
    if (rst)                         flag_q <= 1'b0;
    else if (evt)                    flag_q <= 1'b1;
    else if (ctrl_wr && !wr_flag_bit) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (ctrl_wr) en_q <= wr_en_bit;
  end

  assign pull_low = flag_q && en_q;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int N  = NUM_FIELDS,
  parameter int DW = REG_W,
  parameter int AW = ADDR_W,
  localparam int TW = DW - 1,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] cur_minute,
  input  logic [TW-1:0] cur_hour,
  input  logic [TW-1:0] cur_weekday,
  input  logic [TW-1:0] cur_date,
  input  logic          minute_tick,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          int_pull_low
);
  logic [N-1:0][DW-1:0] alarm_q;
  logic [N-1:0][TW-1:0] cur_time;
  logic                 evt;
  logic                 excl_all;
  logic                 flag_q;
  logic                 en_q;
  logic                 ctrl_wr;
  logic [AW-1:0]        rd_off;
  logic                 rd_in_alarm;
  logic [DW-1:0]        rd_next;

  assign cur_time[FLD_MINUTE]  = cur_minute;
  assign cur_time[FLD_HOUR]    = cur_hour;
  assign cur_time[FLD_WEEKDAY] = cur_weekday;
  assign cur_time[FLD_DATE]    = cur_date;

  assign ctrl_wr = reg_wr && (reg_addr == CTRL_ADDR);

  alarm_regfile #(.N(N), .DW(DW), .AW(AW), .BASE(ALARM_BASE)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .alarm_q (alarm_q)
  );

  alarm_matcher #(.N(N), .DW(DW)) u_match (
    .alarm_q  (alarm_q),
    .cur_time (cur_time),
    .tick     (minute_tick),
    .excl_all (excl_all),
    .evt      (evt)
  );

  alarm_flag_ctrl u_flag (
    .clk         (clk),
    .rst         (rst),
    .evt         (evt),
    .ctrl_wr     (ctrl_wr),
    .wr_en_bit   (reg_wdata[EN_BIT]),
    .wr_flag_bit (reg_wdata[FLAG_BIT]),
    .flag_q      (flag_q),
    .en_q        (en_q),
    .pull_low    (int_pull_low)
  );

  // registered read mux
  assign rd_off      = reg_addr - ALARM_BASE;
  assign rd_in_alarm = (reg_addr >= ALARM_BASE) && (rd_off < AW'(N));

  always_comb begin
    rd_next = '0;
    if (rd_in_alarm) begin
      rd_next = alarm_q[rd_off[IW-1:0]];
    end else if (reg_addr == CTRL_ADDR) begin
      rd_next[EN_BIT]   = en_q;
      rd_next[FLAG_BIT] = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       evt,
  input logic       excl_all,
  input logic       flag_q,
  input logic       en_q,
  input logic       ctrl_wr,
  input logic [7:0] reg_wdata,
  input logic       int_pull_low
);
  // R6
  all_excl_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
    excl_all |-> !evt);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(ctrl_wr && !reg_wdata[1])) |=> flag_q);

  // R4
  flag_needs_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !evt) |=> !flag_q);

  // R11
  en_clear_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !reg_wdata[0]) |=> !int_pull_low);

  // R9
  evt_enabled_pull_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && en_q && !ctrl_wr) |=> int_pull_low);

  // R8
  evt_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag_q);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .evt          (evt),
  .excl_all     (excl_all),
  .flag_q       (flag_q),
  .en_q         (en_q),
  .ctrl_wr      (ctrl_wr),
  .reg_wdata    (reg_wdata),
  .int_pull_low (int_pull_low)
);

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] cur_minute, cur_hour, cur_weekday, cur_date;
  logic       minute_tick;
  logic       reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       int_pull_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_irq u_dut (
    .clk(clk), .rst(rst),
    .cur_minute(cur_minute), .cur_hour(cur_hour),
    .cur_weekday(cur_weekday), .cur_date(cur_date),
    .minute_tick(minute_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_pull_low(int_pull_low)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_alarm [4];
  logic       m_flag, m_en;

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_evt(logic [6:0] mi, logic [6:0] h,
                                   logic [6:0] w, logic [6:0] d);
    logic [6:0] t [4];
    bit any_in = 0;
    bit all_eq = 1;
    t[0] = mi; t[1] = h; t[2] = w; t[3] = d;
    for (int i = 0; i < 4; i++) begin
      if (!m_alarm[i][7]) begin
        any_in = 1;
        if (m_alarm[i][6:0] != t[i]) all_eq = 0;
      end
    end
    return any_in && all_eq;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a >= 4'h9 && a <= 4'hC) m_alarm[a - 4'h9] = d;
    if (a == 4'h1) begin
      m_en = d[0];
      if (!d[1]) m_flag = 1'b0;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic check_pin(string req);
    check_eq(req, int_pull_low, m_flag & m_en);
  endtask

  task automatic check_ctrl(string req);
    logic [7:0] d;
    rd(4'h1, d);
    check_eq(req, d, {6'b0, m_flag, m_en});
  endtask

  task automatic set_time(logic [6:0] mi, logic [6:0] h, logic [6:0] w, logic [6:0] d);
    cur_minute = mi; cur_hour = h; cur_weekday = w; cur_date = d;
  endtask

  task automatic tick(logic [6:0] mi, logic [6:0] h, logic [6:0] w, logic [6:0] d);
    @(negedge clk);
    set_time(mi, h, w, d);
    minute_tick = 1'b1;
    @(negedge clk);
    minute_tick = 1'b0;
    if (model_evt(mi, h, w, d)) m_flag = 1'b1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1A2B3C4D));
    rst = 1'b1; minute_tick = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    set_time(0, 0, 0, 0);
    for (int i = 0; i < 4; i++) m_alarm[i] = 8'h00;
    m_flag = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_eq("R1 pin", int_pull_low, 0);
    for (int i = 9; i <= 12; i++) begin
      rd(4'(i), d);
      check_eq("R1 alarm reg", d, 0);
    end
    check_ctrl("R1 ctrl");

    // R2 write/readback
    wr(4'h9, 8'h30); wr(4'hA, 8'h12); wr(4'hB, 8'h03); wr(4'hC, 8'h25);
    for (int i = 0; i < 4; i++) begin
      rd(4'(9 + i), d);
      check_eq("R2 readback", d, m_alarm[i]);
    end
    rd(4'h5, d);
    check_eq("R3 unmapped", d, 0);

    // R10 event with enable 0
    tick(7'h30, 7'h12, 7'h03, 7'h25);
    check_eq("R10 pin released", int_pull_low, 0);
    check_ctrl("R4 flag set on match");
    wr(4'h1, 8'h03);
    check_eq("R10 enable pulls low", int_pull_low, 1);
    check_ctrl("R8 write 1 keeps flag");
    // R11
    wr(4'h1, 8'h02);
    check_eq("R11 release", int_pull_low, 0);
    check_ctrl("R11 flag kept");
    wr(4'h1, 8'h03);
    check_pin("R9 re-enable");
    wr(4'h1, 8'h01);
    check_eq("R9 flag clear releases", int_pull_low, 0);
    check_ctrl("R8 flag cleared");

    // R7 matching time without tick
    @(negedge clk); set_time(7'h30, 7'h12, 7'h03, 7'h25);
    repeat (3) @(negedge clk);
    check_ctrl("R7 no tick no event");

    // R4 mismatch
    tick(7'h31, 7'h12, 7'h03, 7'h25);
    check_ctrl("R4 mismatch no event");

    // R5 exclude minute
    wr(4'h9, 8'hC5);
    tick(7'h01, 7'h12, 7'h03, 7'h25);
    check_pin("R5 excluded field");
    check_ctrl("R5 flag");

    // R8 event and clear same cycle
    @(negedge clk);
    set_time(7'h02, 7'h12, 7'h03, 7'h25);
    minute_tick = 1'b1; reg_wr = 1'b1; reg_addr = 4'h1; reg_wdata = 8'h01;
    @(negedge clk);
    minute_tick = 1'b0; reg_wr = 1'b0;
    m_en = 1'b1; m_flag = 1'b1;
    check_eq("R8 event wins", int_pull_low, 1);

    // R6 all excluded
    wr(4'h1, 8'h01);
    wr(4'h9, 8'h80); wr(4'hA, 8'h80); wr(4'hB, 8'h80); wr(4'hC, 8'h80);
    tick(7'h00, 7'h00, 7'h00, 7'h00);
    check_eq("R6 no event", int_pull_low, 0);
    check_ctrl("R6 flag");

    // R3 unused control bits
    wr(4'h1, 8'hFC);
    check_ctrl("R3 ctrl bits");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [7:0] v = 8'($urandom);
        v[7] = ($urandom_range(0, 3) == 0);
        wr(4'(9 + $urandom_range(0, 3)), v);
      end else if (op < 5) begin
        wr(4'h1, 8'($urandom));
        check_pin("R9 random ctrl");
      end else if (op < 9) begin
        logic [6:0] t [4];
        for (int i = 0; i < 4; i++)
          t[i] = ($urandom_range(0, 2) != 0) ? m_alarm[i][6:0] : 7'($urandom);
        tick(t[0], t[1], t[2], t[3]);
        check_pin("R4 random tick");
      end else begin
        int a = $urandom_range(9, 12);
        rd(4'(a), d);
        check_eq("R2 random read", d, m_alarm[a - 9]);
        check_ctrl("R8 random flag");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule